// File: doc/BRIEF.md
# Twelve-Line GPIO Controller with Latched Level Interrupts

This block gives software control over twelve general-purpose pins through a small 32-bit register port. Each pin has an output value and an output enable. When the enable bit for a pin is clear, the pin is released. Pin inputs pass through a two-flop synchronizer. The synchronized values are visible in a read-only input register, and they also feed the interrupt logic.

Every line can raise an interrupt on a level, either high or low. The active level is chosen by one polarity bit per line. A detected level is captured in a sticky status register, and software clears a status bit by writing a one to it. The status register is ANDed with an enable mask, and the bits of the result are ORed into a single interrupt output. A further 32-bit word is stored for pin-multiplexing logic elsewhere in the chip and is shown on an output port.

Accesses are single-cycle. A write takes effect at the clock edge on which `reg_sel` and `reg_wr` are both high. Read data is combinational from the address while `reg_sel` is high and `reg_wr` is low.

Top module: `gpio_latch_ctrl`

## Requirements
- R1: `pin_oe` equals the output-enable register (offset 0x04) and `pin_out[n]` equals bit n of the output data register (offset 0x00) when `pin_oe[n]` is 1. Otherwise `pin_out[n]` is 0. Both outputs follow a write from the clock edge that performs it.
- R2: The input register (offset 0x08, read-only) shows `pin_in` through two flops, so a pin change becomes readable after the second rising edge.
- R3: The polarity of line n is bit 4*(n mod 8) of the register at offset 0x10 for lines 0 to 7, and of the register at offset 0x18 for lines 8 to 11. All other bits of these two registers read 0.
- R4: With polarity 0 a line is active while its synchronized input is 1, and with polarity 1 while it is 0. An active line sets its status bit (offset 0x0C, bit n) on the edge after the synchronized value becomes active, which is the third edge after the pin changes. Inactive lines never set status.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A status bit stays set after the level goes away. When a clear and an active level fall on the same edge, the set wins and the bit remains 1.
- R6: `irq` is 1 exactly when (status AND mask) is non-zero, where mask is at offset 0x14 and bit n = 1 enables line n. Status bits keep latching while their lines are masked, so unmasking a pending line raises `irq` from the edge of the mask write.
- R7: The register at offset 0x1C holds a full 32-bit word that reads back unchanged and is driven on `mux_cfg`.
- R8: Reset clears every register, so all reads return 0 and `pin_out`, `pin_oe`, `irq` and `mux_cfg` are 0.
- R9: Register bits above bit 11 of the per-line registers read 0. Offsets that are not word-aligned, and word offsets 0x20 and above, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| pin_in | input | 12 | Pin input levels |
| pin_out | output | 12 | Driven pin values |
| pin_oe | output | 12 | Pin drive enables |
| mux_cfg | output | 32 | Stored pin-multiplexing word |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The functions that can collide are a write-one-to-clear on a status bit and level detection on the same line. The bench holds a pin at its active level long enough for the status bit to latch. It then writes a one to that bit while the level is still present. Because the set takes priority on that edge, the read on the following half cycle must still show the bit as 1. The bench then releases the pin, clears the bit again, and expects the bit to read 0.

// File: rtl/gpio_latch_pkg.sv
package gpio_latch_pkg;

    localparam int NUM_LINES     = 12;
    localparam int WORD_W        = 32;
    localparam int ADDR_W        = 6;
    localparam int NUM_REGS      = 8;
    localparam int LINES_PER_POL = 8;
    localparam int POL_STRIDE    = 4;

    typedef enum logic [2:0] {
        RIDX_DOUT   = 3'd0,
        RIDX_OE     = 3'd1,
        RIDX_DIN    = 3'd2,
        RIDX_STAT   = 3'd3,
        RIDX_POL_LO = 3'd4,
        RIDX_MASK   = 3'd5,
        RIDX_POL_HI = 3'd6,
        RIDX_MUX    = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic     rd_hit;
        logic     wr_hit;
        reg_idx_e idx;
    } reg_dec_t;

    function automatic reg_dec_t reg_decode(input logic sel, input logic wr,
                                            input logic [ADDR_W-1:0] addr);
        reg_dec_t d;
        logic     mapped;
        mapped   = (addr[1:0] == 2'b00) && (int'(addr[ADDR_W-1:2]) < NUM_REGS);
        d.rd_hit = sel && !wr && mapped;
        d.wr_hit = sel && wr && mapped;
        d.idx    = reg_idx_e'(addr[4:2]);
        return d;
    endfunction

    // Spread the polarity bits of one half of the lines onto every fourth bit.
    function automatic logic [WORD_W-1:0] pol_pack(input logic [NUM_LINES-1:0] pol,
                                                   input logic upper);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            if ((n >= LINES_PER_POL) == upper)
                w[(n % LINES_PER_POL) * POL_STRIDE] = pol[n];
        end
        return w;
    endfunction

    // Take the polarity bits of one half of the lines from a written word.
    function automatic logic [NUM_LINES-1:0] pol_merge(input logic [NUM_LINES-1:0] pol,
                                                       input logic [WORD_W-1:0] word,
                                                       input logic upper);
        logic [NUM_LINES-1:0] r;
        r = pol;
        for (int n = 0; n < NUM_LINES; n++) begin
            if ((n >= LINES_PER_POL) == upper)
                r[n] = word[(n % LINES_PER_POL) * POL_STRIDE];
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync_stage.sv
module gpio_sync_stage #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;

    AST_SYNC_FIRST:  assert property (@(posedge clk) disable iff (rst) 1'b1 |=> s1_q == $past(d));    // R2
    AST_SYNC_SECOND: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> s2_q == $past(s1_q)); // R2

endmodule

// File: rtl/gpio_level_latch.sv
module gpio_level_latch
    import gpio_latch_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] active;
    logic [N-1:0] stat_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        // polarity 0: high active, polarity 1: low active
        assign active[i] = din[i] ^ pol[i];

        always_ff @(posedge clk) begin
            if (rst)
                stat_q[i] <= 1'b0;
            else
                stat_q[i] <= active[i] | (stat_q[i] & ~clr[i]);
        end
    end

    assign status = stat_q;
    assign irq    = |(stat_q & mask);

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (rst)
        (active != '0) |=> ((stat_q & $past(active)) == $past(active)));                 // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(active)) == '0));                     // R4
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~clr) != '0) |=> ((stat_q & $past(stat_q & ~clr)) == $past(stat_q & ~clr))); // R5

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_latch_pkg::*;
#(
    parameter int N = NUM_LINES,
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_dec_t     dec,
    input  logic [W-1:0] wdata,
    input  logic [N-1:0] din,
    input  logic [N-1:0] status,
    output logic [N-1:0] dout_q,
    output logic [N-1:0] oe_q,
    output logic [N-1:0] pol_q,
    output logic [N-1:0] mask_q,
    output logic [W-1:0] mux_q,
    output logic [N-1:0] stat_clr,
    output logic [W-1:0] rdata
);
    localparam int PAD = W - N;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            oe_q   <= '0;
            pol_q  <= '0;
            mask_q <= '0;
            mux_q  <= '0;
        end else if (dec.wr_hit) begin
            case (dec.idx)
                RIDX_DOUT:   dout_q <= wdata[N-1:0];
                RIDX_OE:     oe_q   <= wdata[N-1:0];
                RIDX_MASK:   mask_q <= wdata[N-1:0];
                RIDX_MUX:    mux_q  <= wdata;
                RIDX_POL_LO: pol_q  <= pol_merge(pol_q, wdata, 1'b0);
                RIDX_POL_HI: pol_q  <= pol_merge(pol_q, wdata, 1'b1);
                default:     ;
            endcase
        end
    end

    assign stat_clr = (dec.wr_hit && dec.idx == RIDX_STAT) ? wdata[N-1:0] : '0;

    always_comb begin
        rdata = '0;
        if (dec.rd_hit) begin
            case (dec.idx)
                RIDX_DOUT:   rdata = {{PAD{1'b0}}, dout_q};
                RIDX_OE:     rdata = {{PAD{1'b0}}, oe_q};
                RIDX_DIN:    rdata = {{PAD{1'b0}}, din};
                RIDX_STAT:   rdata = {{PAD{1'b0}}, status};
                RIDX_POL_LO: rdata = pol_pack(pol_q, 1'b0);
                RIDX_MASK:   rdata = {{PAD{1'b0}}, mask_q};
                RIDX_POL_HI: rdata = pol_pack(pol_q, 1'b1);
                RIDX_MUX:    rdata = mux_q;
                default:     rdata = '0;
            endcase
        end
    end

    AST_MUX_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !(dec.wr_hit && dec.idx == RIDX_MUX) |=> $stable(mux_q));   // R9

endmodule

// File: rtl/gpio_latch_ctrl.sv
module gpio_latch_ctrl
    import gpio_latch_pkg::*;
#(
    parameter int N  = NUM_LINES,
    parameter int W  = WORD_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  pin_oe,
    output logic [W-1:0]  mux_cfg,
    output logic          irq
);
    reg_dec_t     dec;
    logic [N-1:0] din_s;
    logic [N-1:0] dout_q;
    logic [N-1:0] oe_q;
    logic [N-1:0] pol_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] stat_clr;
    logic [N-1:0] status;
    logic [W-1:0] mux_q;

    assign dec = reg_decode(reg_sel, reg_wr, reg_addr);

    gpio_sync_stage #(.W(N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (din_s)
    );

    gpio_reg_bank #(.N(N), .W(W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .wdata    (reg_wdata),
        .din      (din_s),
        .status   (status),
        .dout_q   (dout_q),
        .oe_q     (oe_q),
        .pol_q    (pol_q),
        .mask_q   (mask_q),
        .mux_q    (mux_q),
        .stat_clr (stat_clr),
        .rdata    (reg_rdata)
    );

    gpio_level_latch #(.N(N)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .din    (din_s),
        .pol    (pol_q),
        .clr    (stat_clr),
        .mask   (mask_q),
        .status (status),
        .irq    (irq)
    );

    assign pin_out = dout_q & oe_q;
    assign pin_oe  = oe_q;
    assign mux_cfg = mux_q;

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);                                                          // R6
    AST_DOUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr && reg_addr == 6'h00 && pin_oe == '1)
        |=> pin_out == $past(reg_wdata[N-1:0]));                                           // R1
    AST_MUX_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr && reg_addr == 6'h1C) |=> mux_cfg == $past(reg_wdata));         // R7

endmodule

// File: tb/sim_gpio_latch_ctrl.sv
module sim_gpio_latch_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] pin_in = '0;
    logic [11:0] pin_out;
    logic [11:0] pin_oe;
    logic [31:0] mux_cfg;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpio_latch_ctrl u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .mux_cfg(mux_cfg), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic prep();
        wr(6'h14, 32'h0);
        wr(6'h10, 32'h0);
        wr(6'h18, 32'h0);
        pin_in = '0;
        settle();
        wr(6'h0C, 32'hFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(6'(a * 4), v);
            chk("R8 reset register read", v, 32'h0);
        end
        chk("R8 reset pin_out", {20'h0, pin_out}, 32'h0);
        chk("R8 reset pin_oe", {20'h0, pin_oe}, 32'h0);
        chk("R8 reset irq", {31'h0, irq}, 32'h0);
        chk("R8 reset mux_cfg", mux_cfg, 32'h0);
    endtask

    task automatic t_outputs();
        logic [31:0] v;
        wr(6'h04, 32'hF0F);
        wr(6'h00, 32'hAAA);
        chk("R1 pin_out masked by enable", {20'h0, pin_out}, 32'hA0A);
        chk("R1 pin_oe", {20'h0, pin_oe}, 32'hF0F);
        rd(6'h00, v);
        chk("R1 data readback", v, 32'hAAA);
        wr(6'h04, 32'h0);
        chk("R1 released pins drive 0", {20'h0, pin_out}, 32'h0);
    endtask

    task automatic t_input_sync();
        logic [31:0] v;
        @(negedge clk);
        pin_in = 12'h5A3;
        @(posedge clk); @(negedge clk);
        rd(6'h08, v);
        chk("R2 input after one edge", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(6'h08, v);
        chk("R2 input after two edges", v, 32'h5A3);
    endtask

    task automatic t_polarity();
        logic [31:0] v;
        prep();
        pin_in = 12'h021;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(6'h0C, v);
        chk("R4 status not yet set", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(6'h0C, v);
        chk("R4 high-active lines latched", v, 32'h021);
        wr(6'h10, 32'h0010_0000);   // line 5 low-active
        wr(6'h18, 32'h0000_0010);   // line 9 low-active
        rd(6'h10, v);
        chk("R3 low type register readback", v, 32'h0010_0000);
        rd(6'h18, v);
        chk("R3 high type register readback", v, 32'h0000_0010);
        wr(6'h0C, 32'hFFF);
        rd(6'h0C, v);
        chk("R4 mixed polarity status", v, 32'h201);
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h10, v);
        chk("R3 low type only every fourth bit", v, 32'h1111_1111);
        rd(6'h18, v);
        chk("R3 high type only four bits", v, 32'h0000_1111);
    endtask

    task automatic t_w1c_mask();
        logic [31:0] v;
        prep();
        pin_in = 12'h00F;
        settle();
        pin_in = 12'h000;
        settle();
        rd(6'h0C, v);
        chk("R5 status sticky after level gone", v, 32'h00F);
        wr(6'h0C, 32'h003);
        rd(6'h0C, v);
        chk("R5 write one clears", v, 32'h00C);
        wr(6'h0C, 32'h000);
        rd(6'h0C, v);
        chk("R5 write zero no effect", v, 32'h00C);
        pin_in = 12'h100;
        settle();
        wr(6'h0C, 32'h100);
        rd(6'h0C, v);
        chk("R5 clear while active keeps bit", v, 32'h10C);
        pin_in = 12'h000;
        settle();
        wr(6'h0C, 32'h100);
        rd(6'h0C, v);
        chk("R5 clear after release", v, 32'h00C);
        chk("R6 masked pending lines quiet", {31'h0, irq}, 32'h0);
        wr(6'h14, 32'h004);
        chk("R6 unmask pending raises irq", {31'h0, irq}, 32'h1);
        wr(6'h14, 32'h001);
        chk("R6 mask on idle line drops irq", {31'h0, irq}, 32'h0);
        wr(6'h14, 32'h004);
        wr(6'h0C, 32'h004);
        chk("R6 clear drops irq", {31'h0, irq}, 32'h0);
        rd(6'h14, v);
        chk("R6 mask readback", v, 32'h004);
    endtask

    task automatic t_mux();
        logic [31:0] v;
        wr(6'h1C, 32'hDEAD_BEEF);
        chk("R7 mux_cfg output", mux_cfg, 32'hDEAD_BEEF);
        rd(6'h1C, v);
        chk("R7 mux readback", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(6'h04, 32'hFFF);
        wr(6'h00, 32'h555);
        wr(6'h01, 32'h000);
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h3D, 32'h0);
        wr(6'h3C, 32'h0);
        rd(6'h00, v);
        chk("R9 misaligned write ignored", v, 32'h555);
        chk("R9 pin_out unchanged", {20'h0, pin_out}, 32'h555);
        chk("R9 mux unchanged", mux_cfg, 32'hDEAD_BEEF);
        rd(6'h20, v);
        chk("R9 unmapped read zero", v, 32'h0);
        rd(6'h1E, v);
        chk("R9 misaligned read zero", v, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, v);
        chk("R9 unused upper bits zero", v, 32'h0000_0FFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_outputs();
        t_input_sync();
        t_polarity();
        t_w1c_mask();
        t_mux();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule